// File: doc/BRIEF.md
# WFI Clock-Gating Controller

This block decides when the clock of a processor core and its private L2 cache may be stopped while the core waits for an interrupt, and when that clock must come back. It watches the core's wait-for-interrupt flag, a flag from the power-down sequencer that says the core is in normal operation, a snoop-pending indication from the coherent interconnect, a vector of interrupt wake sources and a gate request from the power-down sequencer. It produces one clock-enable signal that drives an integrated clock-gating cell. The block itself runs on the free-running clock.

A three-state machine (running, gated, waking) tracks the gating decision. A registered gate flag follows the gated state one cycle later. A pending snoop overrides every gate request in the same cycle, so the interconnect never waits on a stopped clock. A build-time parameter can remove WFI gating entirely and leave only the power-down gate path.

The interrupt vector carries machine software, machine timer, machine external and supervisor external interrupts, two non-maskable lines and a message-signalled-interrupt valid. It is `NUM_IRQ` bits wide, and any set bit counts as a wake event.

Top module: `wfi_cg_ctrl`

## Requirements
- R1: After reset, with no power-down gate request and no other stimulus, `clk_en_o` is 1 and stays 1.
- R2: When `core_wfi_i` and `lp_idle_i` are both 1 at a rising edge while the block is running, `clk_en_o` is still 1 after that edge and is 0 after the next edge, provided no snoop is pending.
- R3: While `lp_idle_i` is 0, `core_wfi_i` never causes gating, and `clk_en_o` stays 1.
- R4: Once gated, the block stays gated regardless of `core_wfi_i` and `lp_idle_i` until a wake event or a reset.
- R5: Any single set bit of `irq_vec_i`, including bit 0 and bit `NUM_IRQ-1`, sampled while gated wakes the block: `clk_en_o` is still 0 after that edge and is 1 after the following edge.
- R6: Whenever `snoop_pend_i` is 1, `clk_en_o` is 1 in the same cycle, whatever the gate flag or `pd_gate_i`.
- R7: A pending snoop sampled while gated is also a wake event: with the snoop held for two edges, `clk_en_o` stays 1 after the snoop is released.
- R8: After a wake, the block does not gate again while `core_wfi_i` stays 1. It returns to running at the first edge that samples `core_wfi_i` at 0, after which WFI can gate it again.
- R9: When `pd_gate_i` is 1 and no snoop is pending, `clk_en_o` is 0 in the same cycle.
- R10: With `GATE_EN` set to 0, WFI never lowers `clk_en_o`; only `pd_gate_i` can.
- R11: Asserting `rst_n` low, asynchronously, while gated raises `clk_en_o` to 1 at once, before any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| core_wfi_i | input | 1 | Core is waiting for an interrupt |
| lp_idle_i | input | 1 | Power-down sequencer is idle (normal operation) |
| snoop_pend_i | input | 1 | Snoop flit pending on the receive channel |
| irq_vec_i | input | NUM_IRQ | Interrupt wake sources; any set bit wakes |
| pd_gate_i | input | 1 | Clock gate request from the power-down sequence |
| clk_en_o | output | 1 | Enable for the clock-gating cell |

## Verification
Entry into gating takes two edges: the state register moves at the edge that samples WFI, and the gate flag follows one edge later. An interrupt wake likewise restores the enable two edges after it is sampled. The snoop and power-down paths act within the same cycle, and reset acts at once. The driver applies each input vector at a falling edge and queues the enable value predicted for the window after the next rising edge. The monitor samples a quarter period after that rising edge, so each combinational effect is compared in the cycle it is applied and each registered effect at the exact edge count. The asynchronous reset is checked mid-cycle, before any edge. A second instance built without WFI gating gets the same stimulus and is compared against its own expectations.

// File: rtl/wfi_cg_pkg.sv
package wfi_cg_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_GATED = 2'd1,
        ST_WAKE  = 2'd2
    } cg_state_e;

    typedef struct packed {
        cg_state_e state;
        logic      gate;
    } cg_regs_t;

endpackage

// File: rtl/wfi_cg_wake.sv
module wfi_cg_wake #(
    parameter int NUM_IRQ = 7
) (
    input  logic [NUM_IRQ-1:0] irq_vec,
    input  logic               snoop_pend,
    output logic               wake
);
    // Any interrupt source or a pending snoop ends the gated state.
    always_comb begin
        wake = snoop_pend | (|irq_vec);
    end
endmodule

// File: rtl/wfi_cg_fsm.sv
module wfi_cg_fsm
    import wfi_cg_pkg::*;
#(
    parameter bit GATE_EN = 1'b1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      core_wfi,
    input  logic      lp_idle,
    input  logic      wake,
    output cg_state_e state_o,
    output logic      gate_o
);
    cg_regs_t regs_d, regs_q;
    logic     gate_next;

    // The gate flag follows the gated state one cycle later, or is tied off.
    generate
        if (GATE_EN) begin : g_gate
            assign gate_next = (regs_q.state == ST_GATED);
        end else begin : g_nogate
            assign gate_next = 1'b0;
        end
    endgenerate

    always_comb begin
        regs_d      = regs_q;
        regs_d.gate = gate_next;
        unique case (regs_q.state)
            ST_RUN: begin
                if (core_wfi && lp_idle) begin
                    regs_d.state = ST_GATED;
                end
            end
            ST_GATED: begin
                if (wake) begin
                    regs_d.state = ST_WAKE;
                end
            end
            ST_WAKE: begin
                if (!core_wfi) begin
                    regs_d.state = ST_RUN;
                end
            end
            default: regs_d.state = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{state: ST_RUN, gate: 1'b0};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign state_o = regs_q.state;
    assign gate_o  = regs_q.gate;
endmodule

// File: rtl/wfi_cg_enable.sv
module wfi_cg_enable (
    input  logic wfi_gate,
    input  logic pd_gate,
    input  logic snoop_pend,
    output logic clk_en
);
    // A pending snoop overrides both gate sources in the same cycle.
    always_comb begin
        clk_en = (!wfi_gate && !pd_gate) || snoop_pend;
    end
endmodule

// File: rtl/wfi_cg_ctrl.sv
module wfi_cg_ctrl
    import wfi_cg_pkg::*;
#(
    parameter int NUM_IRQ = 7,
    parameter bit GATE_EN = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               core_wfi_i,
    input  logic               lp_idle_i,
    input  logic               snoop_pend_i,
    input  logic [NUM_IRQ-1:0] irq_vec_i,
    input  logic               pd_gate_i,
    output logic               clk_en_o
);
    logic      wake;
    cg_state_e st_q;
    logic      gate_q;

    wfi_cg_wake #(.NUM_IRQ(NUM_IRQ)) u_wake (
        .irq_vec    (irq_vec_i),
        .snoop_pend (snoop_pend_i),
        .wake       (wake)
    );

    wfi_cg_fsm #(.GATE_EN(GATE_EN)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .core_wfi (core_wfi_i),
        .lp_idle  (lp_idle_i),
        .wake     (wake),
        .state_o  (st_q),
        .gate_o   (gate_q)
    );

    wfi_cg_enable u_en (
        .wfi_gate   (gate_q),
        .pd_gate    (pd_gate_i),
        .snoop_pend (snoop_pend_i),
        .clk_en     (clk_en_o)
    );
endmodule

// File: rtl/wfi_cg_ctrl_chk.sv
module wfi_cg_ctrl_chk
    import wfi_cg_pkg::*;
#(
    parameter int NUM_IRQ = 7,
    parameter bit GATE_EN = 1'b1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               core_wfi_i,
    input logic               lp_idle_i,
    input logic               snoop_pend_i,
    input logic [NUM_IRQ-1:0] irq_vec_i,
    input logic               pd_gate_i,
    input logic               clk_en_o,
    input cg_state_e          st_q,
    input logic               gate_q
);
    p_enter_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && core_wfi_i && lp_idle_i) |=> (st_q == ST_GATED));

    p_no_gate_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && !lp_idle_i) |=> (st_q != ST_GATED));

    p_hold_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_GATED && !snoop_pend_i && irq_vec_i == '0) |=> (st_q == ST_GATED));

    p_irq_wake_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_GATED && irq_vec_i != '0) |=> (st_q == ST_WAKE));

    p_snoop_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_pend_i |-> clk_en_o);

    p_snoop_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_GATED && snoop_pend_i) |=> (st_q == ST_WAKE));

    p_awake_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAKE && !core_wfi_i) |=> (st_q == ST_RUN));

    p_awake_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAKE && core_wfi_i) |=> (st_q == ST_WAKE));

    p_pd_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_gate_i && !snoop_pend_i) |-> !clk_en_o);

    generate
        if (GATE_EN) begin : g_flag
            p_flag_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (st_q == ST_GATED) |=> gate_q);
            p_flag_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (st_q != ST_GATED) |=> !gate_q);
        end else begin : g_noflag
            p_never_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
                !pd_gate_i |-> clk_en_o);
        end
    endgenerate
endmodule

bind wfi_cg_ctrl wfi_cg_ctrl_chk #(.NUM_IRQ(NUM_IRQ), .GATE_EN(GATE_EN)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .core_wfi_i   (core_wfi_i),
    .lp_idle_i    (lp_idle_i),
    .snoop_pend_i (snoop_pend_i),
    .irq_vec_i    (irq_vec_i),
    .pd_gate_i    (pd_gate_i),
    .clk_en_o     (clk_en_o),
    .st_q         (st_q),
    .gate_q       (gate_q)
);

// File: tb/wfi_cg_ctrl_bench.sv
module wfi_cg_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NIRQ       = 7;

    logic            clk   = 1'b0;
    logic            rst_n = 1'b0;
    logic            wfi   = 1'b0;
    logic            idle  = 1'b1;
    logic            snp   = 1'b0;
    logic            pd    = 1'b0;
    logic [NIRQ-1:0] irq   = '0;
    logic            en_a;
    logic            en_b;

    wfi_cg_ctrl #(.NUM_IRQ(NIRQ), .GATE_EN(1'b1)) u_wfi_cg_ctrl (
        .clk(clk), .rst_n(rst_n), .core_wfi_i(wfi), .lp_idle_i(idle),
        .snoop_pend_i(snp), .irq_vec_i(irq), .pd_gate_i(pd), .clk_en_o(en_a)
    );

    wfi_cg_ctrl #(.NUM_IRQ(NIRQ), .GATE_EN(1'b0)) u_wfi_cg_ctrl_off (
        .clk(clk), .rst_n(rst_n), .core_wfi_i(wfi), .lp_idle_i(idle),
        .snoop_pend_i(snp), .irq_vec_i(irq), .pd_gate_i(pd), .clk_en_o(en_b)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic  ea;
        logic  eb;
        string tag;
    } exp_t;

    exp_t sb[$];
    int   n_vec = 0;
    int   n_bad = 0;
    int   mstate = 0; // 0 running, 1 gated, 2 waking

    task automatic chk(input logic act, input logic exp, input string tag);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: clk_en=%b expected %b", tag, act, exp);
        end
    endtask

    // Driver: apply a vector at a falling edge and queue the enable expected
    // after the next rising edge.
    task automatic vec(input logic w, input logic i, input logic s,
                       input logic [NIRQ-1:0] q, input logic p, input string tag);
        exp_t e;
        logic flag_n;
        logic wk;
        @(negedge clk);
        wfi = w; idle = i; snp = s; irq = q; pd = p;
        wk     = s || (q != '0);
        flag_n = (mstate == 1);
        case (mstate)
            0:       if (w && i) mstate = 1;
            1:       if (wk)     mstate = 2;
            default: if (!w)     mstate = 0;
        endcase
        e.ea  = (!flag_n && !p) || s;
        e.eb  = !p || s;
        e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: a quarter period after each rising edge.
    exp_t m_e;
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (sb.size() > 0) begin
                m_e = sb.pop_front();
                chk(en_a, m_e.ea, m_e.tag);
                chk(en_b, m_e.eb, {"R10 ", m_e.tag});
            end
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        #(CLK_PERIOD*5000);
        n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        summary();
        $finish;
    end

    initial begin
        #(CLK_PERIOD/4);
        chk(en_a, 1'b1, "R1 in reset");
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        repeat (4) vec(0, 1, 0, '0, 0, "R1 idle after reset");
        repeat (4) vec(1, 0, 0, '0, 0, "R3 wfi while busy");

        repeat (3) vec(1, 1, 0, '0, 0, "R2 gate entry");
        repeat (3) vec(0, 0, 0, '0, 0, "R4 hold gated");
        vec(0, 1, 0, 7'b0001000, 0, "R5 irq bit3 wake");
        vec(0, 1, 0, '0, 0, "R5 enable back");
        vec(0, 1, 0, '0, 0, "R8 running again");

        repeat (2) vec(1, 1, 0, '0, 0, "R2 gate entry");
        vec(1, 1, 0, 7'b0000001, 0, "R5 irq bit0 wake");
        repeat (4) vec(1, 1, 0, '0, 0, "R8 stays awake in wfi");
        vec(0, 1, 0, '0, 0, "R8 leave wake");
        repeat (3) vec(1, 1, 0, '0, 0, "R8 regate after wake");
        vec(1, 1, 0, 7'b1000000, 0, "R5 irq top bit wake");
        repeat (2) vec(0, 1, 0, '0, 0, "R5 enable back");

        repeat (3) vec(1, 1, 0, '0, 0, "R2 gate entry");
        vec(1, 1, 1, '0, 0, "R6 snoop forces enable");
        vec(1, 1, 1, '0, 0, "R7 snoop held");
        repeat (2) vec(1, 1, 0, '0, 0, "R7 enable after snoop");
        vec(0, 1, 0, '0, 0, "R8 leave wake");

        repeat (2) vec(0, 1, 0, '0, 1, "R9 power-down gate");
        vec(0, 1, 1, '0, 1, "R6 snoop over power-down");
        vec(0, 1, 0, '0, 0, "R9 release");

        repeat (3) vec(1, 1, 0, '0, 0, "R2 gate entry");
        @(negedge clk);
        wfi = 1'b0; idle = 1'b1; snp = 1'b0; irq = '0; pd = 1'b0;
        #(CLK_PERIOD/8);
        rst_n = 1'b0;
        #1;
        chk(en_a, 1'b1, "R11 async reset while gated");
        @(negedge clk);
        rst_n  = 1'b1;
        mstate = 0;
        repeat (2) vec(0, 1, 0, '0, 0, "R1 after async reset");

        repeat (3) @(negedge clk);
        if (sb.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: %0d pending, expected 0", sb.size());
        end
        summary();
        $finish;
    end
endmodule